// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that sits in front of a 128-byte on-chip store and behaves like a small serial EEPROM. SCL and SDA are sampled with the system clock through two-stage synchronizers. SDA is driven through an open-drain enable: when `sda_oe` is high, the pad pulls the line low. The block finds START and STOP conditions and checks the device address. It keeps a 7-bit byte pointer, takes byte writes, and serves sequential reads.

A write has three bytes: the device address, the pointer value, and one data byte. The data byte is only held while the transaction is open. It is committed to storage at the STOP that closes the transaction, and only if `wr_en_i` was high when the byte arrived. The commit starts a programming period of fixed length. For that period the block keeps SDA released and ignores all bus activity, including START.

A read sends bytes from the pointer location, most significant bit first. After each byte the pointer increments. The master's acknowledge decides whether the next byte is sent.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset `sda_oe` is low and every storage byte reads back as 0x00.
- R2: Bus activity seen before any START gets no acknowledge.
- R3: An address byte is accepted when its bits 7..4 equal 1010. Bits 3..1 may take any value, and bit 0 selects read (1) or write (0). On a match, SDA is held low during the ninth clock. On a mismatch, SDA stays high and the block ignores the bus until the next START.
- R4: In a write, the byte after the address loads the pointer, and bit 7 of that byte is ignored. The next byte is data for the pointer location. Both bytes are acknowledged.
- R5: A STOP that follows an accepted data byte programs that byte into storage. The block then stays busy for `PROG_CYCLES` system clocks. While busy it acknowledges nothing, and its address ACK returns once that time has passed.
- R6: A data byte that arrives while `wr_en_i` is low is still acknowledged, but storage is left unchanged. Dropping `wr_en_i` after the STOP does not cancel a programming cycle that has already started.
- R7: A read sends the byte at the pointer, MSB first, and then increments the pointer. When the master acknowledges (SDA low on the ninth clock), the next byte follows. The pointer wraps from 127 to 0.
- R8: When the master does not acknowledge a read byte, the block releases SDA and ignores the bus until STOP or START.
- R9: A repeated START restarts address matching and drops any pending write data, so the following STOP programs nothing.
- R10: `sda_oe` changes only while SCL is low, shortly after an SCL falling edge, except for release on START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen at the pad |
| sda_i | input | 1 | Serial data as seen at the pad |
| wr_en_i | input | 1 | Write enable; must be high for a data byte to be programmed |
| sda_oe | output | 1 | Open-drain enable; high pulls SDA low |

## Verification
A vector table of writes followed by random-access reads covers several cases. It includes pointer values with bit 7 set, which shows whether the top pointer bit is ignored. It includes a write with the enable low, which tells an acknowledged-but-discarded write apart from a real one. Its address bytes vary in the three don't-care bits. A multi-byte read starting at 0x7E shows whether the pointer wraps and whether the master's ACK keeps the stream going. Directed sequences then cover these cases:
- traffic before any START;
- an address that does not match;
- a START during the programming period;
- an enable that drops after STOP;
- clocking on after a NACK;
- a repeated START with a write pending, which separates a discarded write from a committed one.

// File: rtl/ee_pkg.sv
package ee_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK
  } ee_state_e;

  // True when the upper nibble of a received address byte equals the device id.
  function automatic logic dev_match(input logic [7:0] b, input logic [3:0] id);
    return b[7:4] == id;
  endfunction

  // Bit to present after idx bits have already been shifted out, MSB first.
  function automatic logic msb_first_bit(input logic [7:0] b, input logic [3:0] idx);
    logic [2:0] pos;
    pos = 3'd7 - idx[2:0];
    return b[pos];
  endfunction

endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ee_prog_timer.sv
module ee_prog_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             remain <= '0;
    else if (kick)          remain <= LOAD;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/ee_mem_array.sv
module ee_mem_array #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import ee_pkg::*;
#(
  parameter int         AW          = 7,
  parameter int         PROG_CYCLES = 2000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_ID      = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wr_en_i,
  output logic sda_oe
);
  localparam logic [3:0] BITS_DONE = 4'd8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic busy, prog_start, byte_done;
  ee_state_e state;
  logic [3:0]    cnt;
  logic [7:0]    sh, tx, pend_data, rd_byte;
  logic [AW-1:0] ptr, pend_addr;
  logic          pend_valid, rw, mack;

  ee_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  ee_prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .kick(prog_start), .busy(busy)
  );

  ee_mem_array #(.AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(prog_start), .waddr(pend_addr),
    .wdata(pend_data), .raddr(ptr), .rdata(rd_byte)
  );

  // Commit happens on a STOP while an enabled data byte is pending.
  assign prog_start = stop_evt & pend_valid & ~busy;
  assign byte_done  = scl_fall & (cnt == BITS_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sh         <= '0;
      tx         <= '0;
      ptr        <= '0;
      pend_addr  <= '0;
      pend_data  <= '0;
      pend_valid <= 1'b0;
      rw         <= 1'b0;
      mack       <= 1'b0;
      sda_oe     <= 1'b0;
    end else if (busy) begin
      state      <= ST_IDLE;
      sda_oe     <= 1'b0;
      pend_valid <= 1'b0;
    end else if (start_evt) begin
      state      <= ST_ADDR;
      cnt        <= '0;
      sda_oe     <= 1'b0;
      pend_valid <= 1'b0;
    end else if (stop_evt) begin
      state      <= ST_IDLE;
      sda_oe     <= 1'b0;
      pend_valid <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDAT: begin
          if (scl_rise && cnt != BITS_DONE) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            sda_oe <= 1'b1;
            if (state == ST_ADDR) begin
              if (dev_match(sh, DEV_ID)) begin
                state <= ST_ADDR_ACK;
                rw    <= sh[0];
              end else begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
              end
            end else if (state == ST_PTR) begin
              ptr   <= sh[AW-1:0];
              state <= ST_PTR_ACK;
            end else begin
              pend_data  <= sh;
              pend_addr  <= ptr;
              pend_valid <= wr_en_i;
              ptr        <= ptr + 1'b1;
              state      <= ST_WDAT_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              state  <= ST_RDAT;
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else begin
              state  <= ST_PTR;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_PTR_ACK, ST_WDAT_ACK: begin
          if (scl_fall) begin
            state  <= ST_WDAT;
            cnt    <= '0;
            sda_oe <= 1'b0;
          end
        end
        ST_RDAT: begin
          if (scl_rise && cnt != BITS_DONE) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == BITS_DONE) begin
              state  <= ST_RACK;
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
            end else begin
              sda_oe <= ~msb_first_bit(tx, cnt);
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              state  <= ST_RDAT;
              cnt    <= '0;
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[7];
            end else begin
              state  <= ST_IDLE;
              sda_oe <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ee_checker.sv
module ee_checker (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_s,
  input logic start_evt,
  input logic stop_evt,
  input logic scl_fall,
  input logic busy,
  input logic prog_start
);
  // R10: output moves only while the synchronized clock is low, bar START/STOP release
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_s);

  // R5: silent while the programming period runs
  p_quiet_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R5: a commit always opens a busy period
  p_prog_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> busy);

  // R3: SDA is pulled low only right after an SCL falling edge
  p_drive_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R9: a START always leaves the line released
  p_start_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);
endmodule

bind i2c_eeprom_target ee_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .start_evt(start_evt), .stop_evt(stop_evt), .scl_fall(scl_fall),
  .busy(busy), .prog_start(prog_start)
);

// File: tb/i2c_eeprom_target_tb.sv
module i2c_eeprom_target_tb;
  localparam int PROG = 1500;
  localparam int H    = 20;
  localparam int NV   = 13;
  // {is_read, ptr[7:0], data[7:0], wr_en}; for reads data is the expected value
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 8'h05, 8'h3C, 1'b1},
    {1'b1, 8'h05, 8'h3C, 1'b0},
    {1'b0, 8'h85, 8'hA7, 1'b1},
    {1'b1, 8'h05, 8'hA7, 1'b0},
    {1'b0, 8'h10, 8'h55, 1'b0},
    {1'b1, 8'h10, 8'h00, 1'b0},
    {1'b0, 8'h7F, 8'hC3, 1'b1},
    {1'b1, 8'h7F, 8'hC3, 1'b0},
    {1'b0, 8'h00, 8'h01, 1'b1},
    {1'b1, 8'h85, 8'hA7, 1'b0},
    {1'b0, 8'h40, 8'hFF, 1'b1},
    {1'b1, 8'h40, 8'hFF, 1'b0},
    {1'b1, 8'h20, 8'h00, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wr_en = 1'b0;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   total = 0, bad = 0, r10_bad = 0;
  logic oe_prev = 1'b0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  i2c_eeprom_target #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .wr_en_i(wr_en), .sda_oe(sda_oe)
  );

  always @(negedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl_m) r10_bad++;
    oe_prev = sda_oe;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(H/2); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(H/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H/2); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(H/2); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(H/2);
    end
    sda_m = 1'b1; wt(H/2); scl_m = 1'b1; wt(H/2); ack = ~sda_line; wt(H/2);
    scl_m = 1'b0; wt(H/2);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H/2); scl_m = 1'b1; wt(H/2); b[i] = sda_line; wt(H/2); scl_m = 1'b0;
    end
    wt(H/2); sda_m = ~mack; wt(H/2); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(H/2);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] p, input logic [7:0] d, input logic [2:0] dc);
    logic a;
    bus_start();
    send_byte({4'b1010, dc, 1'b0}, a); chk(a, "R3 addr ack", a, 1);
    send_byte(p, a);                   chk(a, "R4 ptr ack", a, 1);
    send_byte(d, a);                   chk(a, "R4/R6 data ack", a, 1);
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] p, input logic [2:0] dc, output logic [7:0] d);
    logic a;
    bus_start();
    send_byte({4'b1010, dc, 1'b0}, a); chk(a, "R3 addr ack", a, 1);
    send_byte(p, a);                   chk(a, "R4 ptr ack", a, 1);
    bus_start();
    send_byte({4'b1010, ~dc, 1'b1}, a); chk(a, "R9 restart addr ack", a, 1);
    recv_byte(d, 1'b0);
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    wt(5);
    chk(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);
    rst_n = 1'b1; wt(5);
    chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);

    // R2: address byte clocked without START
    scl_m = 1'b0; wt(H);
    send_byte(8'hA0, a); chk(!a, "R2 no ack before START", a, 0);
    bus_stop();

    // Vector table
    for (int k = 0; k < NV; k++) begin
      logic [17:0] v;
      v = VEC[k];
      if (!v[17]) begin
        wr_en = v[0];
        do_write(v[16:9], v[8:1], 3'(k));
        wt(PROG + 60);
      end else begin
        do_read(v[16:9], 3'(k), d);
        chk(d == v[8:1], (k == 12) ? "R1 reset content" : "R4/R6 readback", d, v[8:1]);
      end
    end

    // R3: mismatching address
    bus_start();
    send_byte(8'hB0, a); chk(!a, "R3 mismatch nack", a, 0);
    send_byte(8'h12, a); chk(!a, "R3 ignored until START", a, 0);
    bus_stop();

    // R5 and R6: busy after commit, enable dropped after STOP
    wr_en = 1'b1;
    do_write(8'h33, 8'h6E, 3'd5);
    wr_en = 1'b0;
    bus_start();
    send_byte(8'hA0, a); chk(!a, "R5 nack while busy", a, 0);
    bus_stop();
    wt(PROG + 60);
    bus_start();
    send_byte(8'hA0, a); chk(a, "R5 ack after busy", a, 1);
    bus_stop();
    do_read(8'h33, 3'd2, d);
    chk(d == 8'h6E, "R6 enable drop after STOP", d, 8'h6E);

    // R7: sequential read across wrap
    bus_start();
    send_byte(8'hA0, a); send_byte(8'h7E, a);
    bus_start();
    send_byte(8'hA1, a); chk(a, "R7 read addr ack", a, 1);
    recv_byte(d, 1'b1); chk(d == 8'h00, "R7 byte 7E", d, 8'h00);
    recv_byte(d, 1'b1); chk(d == 8'hC3, "R7 byte 7F", d, 8'hC3);
    recv_byte(d, 1'b0); chk(d == 8'h01, "R7 wrap to 00", d, 8'h01);
    // R8: after NACK the block stays off the line
    recv_byte(d, 1'b0); chk(d == 8'hFF, "R8 silent after nack", d, 8'hFF);
    bus_stop();
    bus_start();
    send_byte(8'hA1, a);
    recv_byte(d, 1'b0); chk(d == 8'h00, "R7 current address 01", d, 8'h00);
    bus_stop();

    // R9: repeated START discards pending write
    wr_en = 1'b1;
    bus_start();
    send_byte(8'hA0, a); send_byte(8'h30, a); send_byte(8'h99, a);
    bus_start();
    send_byte(8'hA1, a); chk(a, "R9 restart ack", a, 1);
    recv_byte(d, 1'b0);
    bus_stop();
    wr_en = 1'b0;
    bus_start();
    send_byte(8'hA0, a); chk(a, "R9 not busy after stop", a, 1);
    bus_stop();
    do_read(8'h30, 3'd7, d);
    chk(d == 8'h00, "R9 no programming", d, 8'h00);

    chk(r10_bad == 0, "R10 oe change while SCL high", r10_bad, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule